// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the access address for a four-beat burst in a synchronous memory. A load strobe captures an external address, and that address is the first beat of the burst. Each advance strobe moves the burst to its next beat. Only the two low bits change from beat to beat. The upper bits hold the captured value for the whole burst.

An order-select input picks one of two beat orders. When it is high, the order is interleaved: each beat's low bits equal the start bits XOR the beat count. When it is low, the order is linear: the low bits count up from the start and wrap inside the aligned group of four. The order-select input is sampled together with the load strobe and then holds for the whole burst. A flag marks the fourth beat. An advance past the fourth beat returns to the first address of the burst.

The parameter `TIE_INTERLEAVE` is for boards where the order-select input is left unconnected. When it is set, the block ignores the input and always uses the interleaved order.

Top module: `burst_seq`

## Requirements
- R1: While reset is asserted, `addr_out` is all zeros and `final_beat` is 0.
- R2: One clock edge after `ld_stb` is sampled high, `addr_out` equals the `addr_in` value sampled at that edge, and `final_beat` is 0.
- R3: If `order_sel` was 1 at the load, then after k advances (k = 0..3), `addr_out[1:0]` equals the start bits XOR k.
- R4: If `order_sel` was 0 at the load, then after k advances (k = 0..3), `addr_out[1:0]` equals (start bits + k) modulo 4.
- R5: Between loads, `addr_out[ADDR_W-1:2]` holds the value captured at the last load.
- R6: `final_beat` is 1 exactly when three advances have been taken since the last load, counted modulo 4.
- R7: An advance taken on the fourth beat returns `addr_out` to the loaded address, and `final_beat` goes to 0.
- R8: If `ld_stb` and `adv_stb` are high at the same edge, the load wins. The burst restarts at beat zero from the new address.
- R9: A change of `order_sel` or `addr_in` while no load is sampled has no effect on the sequence in progress.
- R10: At an edge where neither strobe is high, `addr_out` and `final_beat` do not change.
- R11: With `TIE_INTERLEAVE` = 1, the block uses the interleaved order whatever the level of `order_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_stb | input | 1 | Capture `addr_in` and start a burst |
| adv_stb | input | 1 | Step to the next beat |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear wrapping order; sampled at load |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Address of the current beat |
| final_beat | output | 1 | High during the fourth beat |

## Verification
Two strobes can land in the same cycle: a load and an advance. The bench drives both high at one edge in the middle of a burst. It expects the new address with the beat count at zero, and then expects the following advance to start from that new address. A change of `order_sel` can also arrive in the same cycle as an advance partway through a burst. The bench toggles `order_sel` on every advance of the exhaustive sweep over both orders and all four start offsets. Each beat is then judged against the order that was latched at the load.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int   ADDR_W         = 8,
  parameter logic TIE_INTERLEAVE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_stb,
  input  logic              adv_stb,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              final_beat
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      start_q;
  logic [1:0]      beat_q;
  logic            ilv_q;
  logic            ilv_d;
  logic [1:0]      lo_ilv;
  logic [1:0]      lo_lin;

  assign ilv_d = TIE_INTERLEAVE | order_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
      beat_q  <= '0;
      ilv_q   <= 1'b1;
    end else if (ld_stb) begin
      hi_q    <= addr_in[ADDR_W-1:2];
      start_q <= addr_in[1:0];
      beat_q  <= '0;
      ilv_q   <= ilv_d;
    end else if (adv_stb) begin
      beat_q  <= beat_q + 2'd1;
    end
  end

  assign lo_ilv     = start_q ^ beat_q;
  assign lo_lin     = start_q + beat_q;
  assign addr_out   = {hi_q, (ilv_q ? lo_ilv : lo_lin)};
  assign final_beat = (beat_q == 2'd3);

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_stb,
  input logic              adv_stb,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              final_beat
);

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> addr_out == $past(addr_in)); // R2

  AST_LOAD_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> !final_beat); // R6

  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_stb |=> $stable(addr_out[ADDR_W-1:2])); // R5

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_stb && !adv_stb) |=> ($stable(addr_out) && $stable(final_beat))); // R10

  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_stb && !ld_stb) |=> addr_out[1:0] != $past(addr_out[1:0])); // R3

  AST_WRAP_CLEARS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (final_beat && adv_stb && !ld_stb) |=> !final_beat); // R7

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |-> (addr_out == '0 && !final_beat)); // R1

endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .adv_stb(adv_stb),
  .addr_in(addr_in), .addr_out(addr_out), .final_beat(final_beat)
);

// File: tb/tb_burst_seq.sv
module tb_burst_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_stb = 1'b0;
  logic       adv_stb = 1'b0;
  logic       order_sel = 1'b0;
  logic       tied_sel = 1'b0;
  logic [7:0] addr_in = '0;
  logic [7:0] addr_out, addr_out_t;
  logic       final_beat, final_beat_t;
  int         total = 0;
  int         bad = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  burst_seq #(.ADDR_W(8), .TIE_INTERLEAVE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .adv_stb(adv_stb),
    .order_sel(order_sel), .addr_in(addr_in),
    .addr_out(addr_out), .final_beat(final_beat));

  burst_seq #(.ADDR_W(8), .TIE_INTERLEAVE(1'b1)) dut_tied (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .adv_stb(adv_stb),
    .order_sel(tied_sel), .addr_in(addr_in),
    .addr_out(addr_out_t), .final_beat(final_beat_t));

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic ld, input logic av, input logic md, input logic [7:0] a);
    ld_stb = ld; adv_stb = av; order_sel = md; addr_in = a;
    @(posedge clk); #1;
  endtask

  function automatic int exp_lo(input int m, input int s, input int k);
    return m ? ((s ^ k) & 3) : ((s + k) & 3);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 addr", addr_out, 0);
    chk("R1 last", final_beat, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int u = 0; u < 3; u++) begin
          automatic int up = (u == 0) ? 0 : (u == 1) ? 6'h2A : 6'h3F;
          automatic logic [7:0] a = {up[5:0], s[1:0]};
          cyc(1'b1, 1'b0, m[0], a);
          chk("R2 addr", addr_out, a);
          chk("R2 last", final_beat, 0);
          chk("R11 tied", addr_out_t, a);
          for (int k = 1; k < 4; k++) begin
            cyc(1'b0, 1'b1, ~m[0], ~a);
            chk(m ? "R3 lo" : "R4 lo", addr_out[1:0], exp_lo(m, s, k));
            chk("R5 hi R9", addr_out[7:2], up);
            chk("R6 last", final_beat, (k == 3) ? 1 : 0);
            chk("R11 tied lo", addr_out_t[1:0], exp_lo(1, s, k));
          end
          cyc(1'b0, 1'b1, m[0], 8'h00);
          chk("R7 wrap", addr_out, a);
          chk("R7 last", final_beat, 0);
          cyc(1'b0, 1'b0, ~m[0], 8'hFF);
          chk("R10 idle", addr_out, a);
          chk("R10 last", final_beat, 0);
        end
      end
    end

    // R8: load and advance together mid-burst
    cyc(1'b1, 1'b0, 1'b0, 8'h41);
    cyc(1'b0, 1'b1, 1'b0, 8'h00);
    cyc(1'b0, 1'b1, 1'b0, 8'h00);
    cyc(1'b1, 1'b1, 1'b1, 8'hC6);
    chk("R8 restart", addr_out, 8'hC6);
    chk("R8 last", final_beat, 0);
    cyc(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R8 step", addr_out, 8'hC7);
    cyc(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R8 step2", addr_out, 8'hC4);
    cyc(1'b1, 1'b1, 1'b0, 8'h13);
    chk("R8 linear restart", addr_out, 8'h13);
    cyc(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R8 linear step", addr_out, 8'h10);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule